// File: doc/BRIEF.md
# Baud Divisor Search Engine

This unit turns a source clock frequency and a requested line rate into the two configuration words of a UART baud generator. The generator divides the selected source clock through two prescalers (each 1 or 6), an oversampling ratio (16 or 63) and a 10-bit divisor. The unit searches for the least prescaling that lets the divisor fit in 10 bits. It tries the plain 16x setting first. If the divisor is too large, it raises the first prescaler, then the second, and finally the oversampling ratio.

Each attempt computes a rounded quotient on a shared iterative restoring divider, which produces one quotient bit per cycle. A request starts with a one-cycle `start_i` pulse. `busy_o` stays high while the search runs. `done_o` pulses for one cycle when both result words are valid, and the words then hold until the next completion. A requested rate of zero is reported as an error at once. Writing the words into the generator and waiting for the transmitter to drain are left to the caller.

Top module: `baud_search`

## Requirements
- R1: After reset, busy_o, done_o and err_o are 0 and both result words are 0.
- R2: The first attempt uses prescalers 1 and 1 with ratio 16. The divisor is round(rate / (baud*ratio*p1*p2)), computed as (rate + den/2) / den with integer division. If it is at most 1023, the search stops there.
- R3: If the first divisor exceeds 1023, the first prescaler becomes 6 and the divisor is recomputed. If that fits, the search stops.
- R4: If it still exceeds 1023, the second prescaler also becomes 6 and the divisor is recomputed.
- R5: If it still exceeds 1023, the ratio becomes 63 and the divisor is recomputed. The oversampling word is then 0x3F3F3F3F, which is 63 in bits 5:0 of each of its four bytes.
- R6: A divisor of 0 at any attempt is replaced by 1 and ends the search.
- R7: A divisor above 1023 after the ratio-63 attempt is clamped to 1023.
- R8: The baud word has bit 19 set, the first prescaler in bits 17:15, the second in bits 14:12, clk_sel_i in bits 11:10, the divisor in bits 9:0, and all other bits 0.
- R9: When the search ends with ratio 16, the oversampling word is 0.
- R10: busy_o rises on the edge that accepts start_i. With n attempts, done_o pulses for one cycle and busy_o falls n*46 edges later. The words and err_o change only on that edge.
- R11: start_i is ignored while busy_o is high.
- R12: A start with baud_i = 0 sets err_o and pulses done_o on the next edge without raising busy_o. It produces divisor 1023, both prescalers 6, ratio 63 and the given clock index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request pulse, sampled while idle |
| src_rate_i | input | 32 | Source clock frequency in Hz |
| clk_sel_i | input | 2 | Source clock index placed in the baud word |
| baud_i | input | 32 | Requested line rate |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last request had a zero line rate |
| baud_word_o | output | 32 | Packed baud generator word |
| ovs_word_o | output | 32 | Packed oversampling word |

## Verification
A behavioural reference model predicts the number of attempts, the completion edge and both words for each request. It is compared with the ports on every cycle. The directed requests are chosen to end at each of the four escalation steps. Further requests exercise the zero-divisor floor, the 1023 clamp, an exact rounding tie against a value just below it, and a zero line rate. Together they separate the rounding, the escalation order and the bit positions of the packed fields. A conflicting start pulse issued mid-search must leave the result untouched. Random rates and line rates then mix all paths.

// File: rtl/baud_search_pkg.sv
package baud_search_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_DIV} state_e;
  typedef enum logic [1:0] {STEP_BASE, STEP_P1, STEP_P2, STEP_OVS} step_e;

  localparam int unsigned WORD_W   = 32;
  localparam int unsigned SRC_BIT  = 19;
  localparam int unsigned P1_LSB   = 15;
  localparam int unsigned P2_LSB   = 12;
  localparam int unsigned SEL_LSB  = 10;
endpackage

// File: rtl/baud_div_iter.sv
module baud_div_iter #(
  parameter int unsigned W = 44
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         valid_o,
  output logic [W-1:0] quot_o
);
  localparam int unsigned CNT_W = $clog2(W + 1);

  logic [W-1:0]     rem_q, quot_q, dsr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             valid_q;
  logic [W:0]       shifted, diff;

  assign shifted = {rem_q, quot_q[W-1]};
  assign diff    = shifted - {1'b0, dsr_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q   <= '0;
      quot_q  <= '0;
      dsr_q   <= '0;
      cnt_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (start_i) begin
        rem_q  <= '0;
        quot_q <= dividend_i;
        dsr_q  <= divisor_i;
        cnt_q  <= CNT_W'(W);
      end else if (cnt_q != '0) begin
        // restoring step: keep trial difference when non-negative
        if (!diff[W]) begin
          rem_q  <= diff[W-1:0];
          quot_q <= {quot_q[W-2:0], 1'b1};
        end else begin
          rem_q  <= shifted[W-1:0];
          quot_q <= {quot_q[W-2:0], 1'b0};
        end
        cnt_q   <= cnt_q - 1'b1;
        valid_q <= (cnt_q == CNT_W'(1));
      end
    end
  end

  assign valid_o = valid_q;
  assign quot_o  = quot_q;
endmodule

// File: rtl/baud_word_pack.sv
module baud_word_pack
  import baud_search_pkg::*;
#(
  parameter int unsigned DIV_W      = 10,
  parameter int unsigned PRE_W      = 3,
  parameter int unsigned SEL_W      = 2,
  parameter int unsigned OVS_FIELDS = 4,
  parameter int unsigned OVS_RATIO  = 63
) (
  input  logic [DIV_W-1:0]  div_i,
  input  logic [PRE_W-1:0]  p1_i,
  input  logic [PRE_W-1:0]  p2_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              ovs_en_i,
  output logic [WORD_W-1:0] baud_word_o,
  output logic [WORD_W-1:0] ovs_word_o
);
  localparam int unsigned FIELD_W = WORD_W / OVS_FIELDS;

  always_comb begin
    baud_word_o                      = '0;
    baud_word_o[DIV_W-1:0]           = div_i;
    baud_word_o[SEL_LSB +: SEL_W]    = sel_i;
    baud_word_o[P2_LSB +: PRE_W]     = p2_i;
    baud_word_o[P1_LSB +: PRE_W]     = p1_i;
    baud_word_o[SRC_BIT]             = 1'b1;
  end

  for (genvar f = 0; f < OVS_FIELDS; f++) begin : g_ovs
    assign ovs_word_o[f*FIELD_W +: FIELD_W] = ovs_en_i ? FIELD_W'(OVS_RATIO) : '0;
  end
endmodule

// File: rtl/baud_search.sv
module baud_search
  import baud_search_pkg::*;
#(
  parameter int unsigned RATE_W     = 32,
  parameter int unsigned SEL_W      = 2,
  parameter int unsigned DIV_W      = 10,
  parameter int unsigned PRE_W      = 3,
  parameter int unsigned PRE_MAX    = 6,
  parameter int unsigned BASE_RATIO = 16,
  parameter int unsigned HIGH_RATIO = 63
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [RATE_W-1:0] src_rate_i,
  input  logic [SEL_W-1:0]  clk_sel_i,
  input  logic [RATE_W-1:0] baud_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [WORD_W-1:0] baud_word_o,
  output logic [WORD_W-1:0] ovs_word_o
);
  localparam int unsigned CALC_W  = RATE_W + $clog2(HIGH_RATIO * PRE_MAX * PRE_MAX);
  localparam int unsigned DIV_MAX = (1 << DIV_W) - 1;

  state_e            st_q;
  step_e             step_q, step_nx;
  logic [RATE_W-1:0] rate_q, baud_q;
  logic [SEL_W-1:0]  sel_q;
  logic              done_q, err_q;
  logic [WORD_W-1:0] bw_q, ow_q;

  logic [CALC_W-1:0] ratio_w, p1_w, p2_w, denom, dividend, quot;
  logic              div_valid, fits, finish;
  logic [DIV_W-1:0]  div_fix;

  always_comb begin
    ratio_w  = (step_q == STEP_OVS) ? CALC_W'(HIGH_RATIO) : CALC_W'(BASE_RATIO);
    p1_w     = (step_q != STEP_BASE) ? CALC_W'(PRE_MAX) : CALC_W'(1);
    p2_w     = (step_q == STEP_P2 || step_q == STEP_OVS) ? CALC_W'(PRE_MAX) : CALC_W'(1);
    denom    = CALC_W'(baud_q) * ratio_w * p1_w * p2_w;
    dividend = CALC_W'(rate_q) + (denom >> 1);
  end

  baud_div_iter #(.W(CALC_W)) i_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (st_q == ST_LOAD),
    .dividend_i (dividend),
    .divisor_i  (denom),
    .valid_o    (div_valid),
    .quot_o     (quot)
  );

  always_comb begin
    fits   = (quot <= CALC_W'(DIV_MAX));
    finish = fits || (step_q == STEP_OVS);
    if (quot == '0)  div_fix = DIV_W'(1);
    else if (!fits)  div_fix = DIV_W'(DIV_MAX);
    else             div_fix = quot[DIV_W-1:0];
    unique case (step_q)
      STEP_BASE: step_nx = STEP_P1;
      STEP_P1:   step_nx = STEP_P2;
      default:   step_nx = STEP_OVS;
    endcase
  end

  // packer inputs: error word while idle, search result otherwise
  logic              idle_w;
  logic [DIV_W-1:0]  pk_div;
  logic [PRE_W-1:0]  pk_p1, pk_p2;
  logic [SEL_W-1:0]  pk_sel;
  logic              pk_ovs;
  logic [WORD_W-1:0] pk_bw, pk_ow;

  assign idle_w = (st_q == ST_IDLE);
  assign pk_div = idle_w ? DIV_W'(DIV_MAX) : div_fix;
  assign pk_p1  = (idle_w || step_q != STEP_BASE) ? PRE_W'(PRE_MAX) : PRE_W'(1);
  assign pk_p2  = (idle_w || step_q == STEP_P2 || step_q == STEP_OVS) ? PRE_W'(PRE_MAX) : PRE_W'(1);
  assign pk_sel = idle_w ? clk_sel_i : sel_q;
  assign pk_ovs = idle_w || (step_q == STEP_OVS);

  baud_word_pack #(
    .DIV_W     (DIV_W),
    .PRE_W     (PRE_W),
    .SEL_W     (SEL_W),
    .OVS_FIELDS(4),
    .OVS_RATIO (HIGH_RATIO)
  ) i_pack (
    .div_i      (pk_div),
    .p1_i       (pk_p1),
    .p2_i       (pk_p2),
    .sel_i      (pk_sel),
    .ovs_en_i   (pk_ovs),
    .baud_word_o(pk_bw),
    .ovs_word_o (pk_ow)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      step_q <= STEP_BASE;
      rate_q <= '0;
      baud_q <= '0;
      sel_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      bw_q   <= '0;
      ow_q   <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          if (baud_i == '0) begin
            err_q  <= 1'b1;
            done_q <= 1'b1;
            bw_q   <= pk_bw;
            ow_q   <= pk_ow;
          end else begin
            rate_q <= src_rate_i;
            baud_q <= baud_i;
            sel_q  <= clk_sel_i;
            step_q <= STEP_BASE;
            st_q   <= ST_LOAD;
          end
        end
        ST_LOAD: st_q <= ST_DIV;
        default: if (div_valid) begin
          if (finish) begin
            err_q  <= 1'b0;
            done_q <= 1'b1;
            bw_q   <= pk_bw;
            ow_q   <= pk_ow;
            st_q   <= ST_IDLE;
          end else begin
            step_q <= step_nx;
            st_q   <= ST_LOAD;
          end
        end
      endcase
    end
  end

  assign busy_o      = !idle_w;
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign baud_word_o = bw_q;
  assign ovs_word_o  = ow_q;
endmodule

// File: rtl/baud_search_chk.sv
module baud_search_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic        busy_o,
  input logic        done_o,
  input logic        err_o,
  input logic [31:0] baud_word_o,
  input logic [31:0] ovs_word_o
);
  // R10
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R10
  results_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(baud_word_o) && $stable(ovs_word_o) && $stable(err_o)));

  // R11
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> (busy_o || done_o));

  // R8
  word_layout_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (baud_word_o[19] && baud_word_o[31:20] == '0 && baud_word_o[18] == 1'b0
                && (baud_word_o[17:15] == 3'd1 || baud_word_o[17:15] == 3'd6)
                && (baud_word_o[14:12] == 3'd1 || baud_word_o[14:12] == 3'd6)));

  // R6
  div_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (baud_word_o[9:0] != 10'd0));

  // R9
  ovs_form_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (ovs_word_o == 32'h0 || ovs_word_o == 32'h3f3f3f3f));

  // R5
  ovs_full_pre_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && ovs_word_o != 32'h0) |-> (baud_word_o[17:15] == 3'd6 && baud_word_o[14:12] == 3'd6));

  // R12
  zero_rate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o) |-> (baud_word_o[9:0] == 10'd1023 && ovs_word_o == 32'h3f3f3f3f));
endmodule

bind baud_search baud_search_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .err_o      (err_o),
  .baud_word_o(baud_word_o),
  .ovs_word_o (ovs_word_o)
);

// File: tb/test_baud_search.sv
module test_baud_search;
  localparam int ATT_CYC = 46;

  logic        clk_i = 0;
  logic        rst_ni = 0;
  logic        start_i = 0;
  logic [31:0] src_rate_i = 0;
  logic [1:0]  clk_sel_i = 0;
  logic [31:0] baud_i = 0;
  logic        busy_o, done_o, err_o;
  logic [31:0] baud_word_o, ovs_word_o;

  int total = 0, bad = 0, cyc = 0;
  string cur_tag = "R2";

  baud_search i_baud_search (.*);

  always #2.5 clk_i = ~clk_i;

  // reference model state
  bit          busy_m = 0, done_m = 0, err_m = 0;
  int          rem_m = 0;
  logic [31:0] bw_m = 0, ow_m = 0;

  function automatic void ref_calc(input longint unsigned rate, input longint unsigned baud,
                                   input int sel, output int n, output logic [31:0] bw,
                                   output logic [31:0] ow, output bit er);
    longint unsigned p1, p2, ratio, den, q;
    bit stop = 0;
    n = 0; q = 0; p1 = 1; p2 = 1; ratio = 16;
    if (baud == 0) begin
      er = 1;
      bw = (32'd1 << 19) | (32'd6 << 15) | (32'd6 << 12) | (32'(sel) << 10) | 32'd1023;
      ow = 32'h3f3f3f3f;
      return;
    end
    er = 0;
    for (int k = 0; k < 4 && !stop; k++) begin
      p1 = (k >= 1) ? 6 : 1;
      p2 = (k >= 2) ? 6 : 1;
      ratio = (k == 3) ? 63 : 16;
      den = baud * ratio * p1 * p2;
      q = (rate + den / 2) / den;
      n = k + 1;
      if (q < 1) begin q = 1; stop = 1; end
      else if (q <= 1023) stop = 1;
      else if (k == 3) q = 1023;
    end
    bw = (32'd1 << 19) | (32'(p1) << 15) | (32'(p2) << 12) | (32'(sel) << 10) | 32'(q);
    ow = (ratio == 63) ? 32'h3f3f3f3f : 32'h0;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_m = 0; done_m = 0; err_m = 0; rem_m = 0; bw_m = 0; ow_m = 0;
    end else begin
      int n;
      logic [31:0] bw, ow;
      bit er;
      done_m = 0;
      if (busy_m) begin
        rem_m--;
        if (rem_m == 0) begin busy_m = 0; done_m = 1; end
      end else if (start_i) begin
        ref_calc(src_rate_i, baud_i, clk_sel_i, n, bw, ow, er);
        if (er) begin
          done_m = 1; err_m = 1; bw_m = bw; ow_m = ow;
        end else begin
          busy_m = 1; rem_m = n * ATT_CYC; err_m = 0; bw_m = bw; ow_m = ow;
        end
      end
    end
  end

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: got=%h exp=%h", tag, what, act, exp);
    end
  endtask

  // compare on every clock, away from the active edge
  always @(negedge clk_i) begin
    if (rst_ni) begin
      check("R10", "busy", 32'(busy_o), 32'(busy_m));
      check("R10", "done", 32'(done_o), 32'(done_m));
      if (done_m) begin
        check(cur_tag, "baud word R8", baud_word_o, bw_m);
        check(cur_tag, "ovs word", ovs_word_o, ow_m);
        check(cur_tag, "err R12", 32'(err_o), 32'(err_m));
      end
    end
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog: got=%0d exp<=150000 cycles", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic req(longint unsigned rate, int sel, longint unsigned baud, string tag);
    @(negedge clk_i);
    while (busy_m) @(negedge clk_i);
    cur_tag = tag;
    src_rate_i = 32'(rate); clk_sel_i = 2'(sel); baud_i = 32'(baud); start_i = 1;
    @(negedge clk_i);
    start_i = 0;
    while (busy_m) @(negedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin
    #12;
    // R1 reset state
    check("R1", "busy", 32'(busy_o), 0);
    check("R1", "done", 32'(done_o), 0);
    check("R1", "err", 32'(err_o), 0);
    check("R1", "baud word", baud_word_o, 0);
    check("R1", "ovs word", ovs_word_o, 0);
    @(negedge clk_i);
    rst_ni = 1;

    req(25_000_000, 1, 115200, "R2 R9");
    req(24, 0, 1, "R2 tie");
    req(23, 3, 1, "R2 below tie");
    req(200_000_000, 2, 9600, "R3");
    req(200_000_000, 3, 1200, "R4");
    req(200_000_000, 1, 300, "R5");
    req(32'hffff_ffff, 0, 10, "R7");
    req(1000, 2, 1_000_000, "R6");
    req(32'hffff_ffff, 1, 32'hffff_ffff, "R6 max");
    req(100, 3, 0, "R12");

    // R11: conflicting start mid-search must not disturb the result
    @(negedge clk_i);
    cur_tag = "R11 R5";
    src_rate_i = 200_000_000; clk_sel_i = 1; baud_i = 300; start_i = 1;
    @(negedge clk_i);
    start_i = 0;
    repeat (20) @(negedge clk_i);
    src_rate_i = 5; clk_sel_i = 2; baud_i = 0; start_i = 1;
    @(negedge clk_i);
    start_i = 0;
    while (busy_m) @(negedge clk_i);
    @(negedge clk_i);

    for (int i = 0; i < 20; i++)
      req($urandom, i % 4, ($urandom % 3_000_000) + 1, "R2 R3 R4 R5 random");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule